// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block models the command side of a parallel NOR-style flash. It watches write bus cycles and commits each write when the active-low write strobe rises. It recognises the six-write erase grammar: two unlock writes, a set-up code, two more unlock writes, then either a whole-array erase code or a single-sector erase code. The sector erase code carries the sector address. No storage array is modelled. The erase is a countdown of a configurable number of clock cycles.

Progress is polled over the read bus. A read aimed at an erasing bank returns a status byte: a done/busy bit, two toggle bits and a start-window bit. A read aimed anywhere else returns the erased byte value. A sector erase first opens a start window timed from its final write strobe, and counts only after the window closes. While a sector erase runs, it can be suspended and resumed. A chip erase ignores every write. An asynchronous active-low reset aborts any erase at once.

Top module: `flash_erase_seq`

## Requirements
- R1: A write commits on the clock edge where `we_n` is seen rising after having been low. The sequence is 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, where the address is compared on its low 11 bits. Any committed write that does not match the next expected step returns the decoder to idle, and no erase starts.
- R2: A sixth write of 0x10 to address 0x555 starts a chip erase. All `bank_busy` bits go high on the commit edge, and they all clear exactly ERASE_CYC edges later.
- R3: A sixth write of 0x30 to any address starts a sector erase. The sector is `addr[11:8]` and the bank is `addr[11:10]`. Only that bank's `bank_busy` bit goes high on the commit edge, and it clears TIMEOUT_CYC + ERASE_CYC edges later.
- R4: Status bit 3 reads 0 for a read sampled on any of the TIMEOUT_CYC edges after the sector erase commit edge. It reads 1 after that. For a chip erase it always reads 1.
- R5: The status byte is {bit7, bit6, 0, 0, bit3, bit2, 0, 0}. While an erase is active, bit7 is 0. Bit6 starts at 0 on launch and inverts after every read that targets an erasing bank.
- R6: Bit2 starts at 0 on launch and inverts only after reads that fall inside the erasing sector. For a chip erase, every sector counts as erasing.
- R7: During a sector erase, reads of any other bank return ERASED_BYTE (0xFF).
- R8: During a chip erase, every write is ignored, including 0xB0, and the completion edge does not move.
- R9: During a sector erase, every write other than 0xB0 is ignored, and the completion edge does not move.
- R10: A 0xB0 write during a sector erase freezes its count and clears `bank_busy`. In that state, reads of the suspended sector return bit7 = 1, bit6 held and bit2 toggling. Other addresses return 0xFF. A later 0x30 write resumes the erase. Completion then moves later by (resume edge − suspend edge + 1).
- R11: After completion, every read returns 0xFF, the sector latch is cleared, and a new six-write sequence is accepted.
- R12: Asserting `rst_n` low clears `bank_busy` without waiting for a clock edge. After release, reads return 0xFF.
- R13: `rdata` is registered: it reflects the read presented with `rd_en` on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset; aborts any erase |
| we_n | input | 1 | Active-low write strobe; the write commits when it rises |
| rd_en | input | 1 | Read request for `addr`, sampled on the clock edge |
| addr | input | ADDR_W (12) | Bus address shared by reads and writes |
| wdata | input | 8 | Write data byte (command code) |
| rdata | output | 8 | Registered read data: either a status byte or ERASED_BYTE |
| bank_busy | output | 2**BANK_W (4) | One bit per bank, high while that bank is actively erasing |

## Verification
Each write is taken at its commit edge, which is the posedge between the strobe's low and high phases. The bench counts posedges, records each commit edge, and compares it with the edge on which `bank_busy` falls. That edge is due TIMEOUT_CYC + ERASE_CYC edges after a sector launch, ERASE_CYC edges after a chip launch, and later by the frozen span after a suspend. Read data is due one edge after `rd_en`, so every read is sampled on the following negative edge. The start-window reads are placed on the last edge inside the window and the first edge after it. Toggle expectations come from a small bench model of the two toggle bits, cleared at each launch.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int UNLOCK_AW = 11;

  localparam logic [UNLOCK_AW-1:0] ADDR_KEY_A = 11'h555;
  localparam logic [UNLOCK_AW-1:0] ADDR_KEY_B = 11'h2AA;

  localparam logic [7:0] CODE_KEY_A  = 8'hAA;
  localparam logic [7:0] CODE_KEY_B  = 8'h55;
  localparam logic [7:0] CODE_SETUP  = 8'h80;
  localparam logic [7:0] CODE_CHIP   = 8'h10;
  localparam logic [7:0] CODE_SECTOR = 8'h30;
  localparam logic [7:0] CODE_HOLD   = 8'hB0;

  typedef enum logic [2:0] {
    DEC_IDLE, DEC_KEY1, DEC_KEY2, DEC_SETUP, DEC_KEY3, DEC_KEY4
  } dec_state_t;

  typedef enum logic [1:0] {
    ENG_IDLE, ENG_WINDOW, ENG_RUN, ENG_SUSP
  } eng_state_t;

  // Status byte layout: done, toggle, window-closed, sector toggle.
  function automatic logic [7:0] status_byte(input logic done, input logic tog_all,
                                             input logic win_closed, input logic tog_sect);
    return {done, tog_all, 2'b00, win_closed, tog_sect, 2'b00};
  endfunction

  function automatic logic key_match(input logic [UNLOCK_AW-1:0] a, input logic [7:0] d,
                                     input logic [UNLOCK_AW-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

endpackage

// File: rtl/fes_cmd_decoder.sv
module fes_cmd_decoder
  import flash_erase_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_commit,
  input  logic                 eng_idle,
  input  logic [UNLOCK_AW-1:0] key_addr,
  input  logic [7:0]           wdata,
  output logic                 launch_chip,
  output logic                 launch_sector
);

  dec_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!eng_idle) begin
      st_d = DEC_IDLE;
    end else if (wr_commit) begin
      unique case (st_q)
        DEC_IDLE:  st_d = key_match(key_addr, wdata, ADDR_KEY_A, CODE_KEY_A) ? DEC_KEY1  : DEC_IDLE;
        DEC_KEY1:  st_d = key_match(key_addr, wdata, ADDR_KEY_B, CODE_KEY_B) ? DEC_KEY2  : DEC_IDLE;
        DEC_KEY2:  st_d = key_match(key_addr, wdata, ADDR_KEY_A, CODE_SETUP) ? DEC_SETUP : DEC_IDLE;
        DEC_SETUP: st_d = key_match(key_addr, wdata, ADDR_KEY_A, CODE_KEY_A) ? DEC_KEY3  : DEC_IDLE;
        DEC_KEY3:  st_d = key_match(key_addr, wdata, ADDR_KEY_B, CODE_KEY_B) ? DEC_KEY4  : DEC_IDLE;
        DEC_KEY4:  st_d = DEC_IDLE;
        default:   st_d = DEC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DEC_IDLE;
    else        st_q <= st_d;
  end

  assign launch_chip   = wr_commit && eng_idle && (st_q == DEC_KEY4) &&
                         key_match(key_addr, wdata, ADDR_KEY_A, CODE_CHIP);
  assign launch_sector = wr_commit && eng_idle && (st_q == DEC_KEY4) && (wdata == CODE_SECTOR);

endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
  import flash_erase_pkg::*;
#(
  parameter int SECT_W      = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter int ERASE_CYC   = 40,
  parameter int CNT_W       = 6
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_chip,
  input  logic              launch_sector,
  input  logic [SECT_W-1:0] sect_in,
  input  logic              hold_req,
  input  logic              resume_req,
  output eng_state_t        state,
  output logic [CNT_W-1:0]  cnt,
  output logic              mode_chip,
  output logic [SECT_W-1:0] sect_q,
  output logic              in_window,
  output logic              suspend_hit,
  output logic              resume_hit,
  output logic              erase_done
);

  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [CNT_W-1:0] RUN_LOAD = CNT_W'(ERASE_CYC - 1);

  logic from_window;

  assign suspend_hit = hold_req && !mode_chip && (state == ENG_WINDOW || state == ENG_RUN);
  assign resume_hit  = resume_req && (state == ENG_SUSP);
  assign erase_done  = (state == ENG_RUN) && (cnt == '0) && !suspend_hit;
  assign in_window   = (state == ENG_WINDOW) || (state == ENG_SUSP && from_window);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ENG_IDLE;
      cnt         <= '0;
      mode_chip   <= 1'b0;
      sect_q      <= '0;
      from_window <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (launch_chip) begin
            state     <= ENG_RUN;
            cnt       <= RUN_LOAD;
            mode_chip <= 1'b1;
          end else if (launch_sector) begin
            state     <= ENG_WINDOW;
            cnt       <= WIN_LOAD;
            mode_chip <= 1'b0;
            sect_q    <= sect_in;
          end
        end
        ENG_WINDOW: begin
          if (suspend_hit) begin
            state       <= ENG_SUSP;
            from_window <= 1'b1;
          end else if (cnt == '0) begin
            state <= ENG_RUN;
            cnt   <= RUN_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_RUN: begin
          if (suspend_hit) begin
            state       <= ENG_SUSP;
            from_window <= 1'b0;
          end else if (cnt == '0) begin
            state     <= ENG_IDLE;
            mode_chip <= 1'b0;
            sect_q    <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_SUSP: begin
          if (resume_hit) state <= from_window ? ENG_WINDOW : ENG_RUN;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fes_status_port.sv
module fes_status_port
  import flash_erase_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         SECT_W      = 4,
  parameter int         BANK_W      = 2,
  parameter logic [7:0] ERASED_BYTE = 8'hFF
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  eng_state_t        state,
  input  logic              mode_chip,
  input  logic [SECT_W-1:0] sect_q,
  input  logic              in_window,
  input  logic              launch,
  output logic [7:0]        rdata
);

  logic tog_all, tog_sect;
  logic active, held, hit_bank, hit_sect;
  logic [7:0] rd_val;

  assign active   = (state == ENG_WINDOW) || (state == ENG_RUN);
  assign held     = (state == ENG_SUSP);
  assign hit_bank = mode_chip || (addr[ADDR_W-1 -: BANK_W] == sect_q[SECT_W-1 -: BANK_W]);
  assign hit_sect = mode_chip || (addr[ADDR_W-1 -: SECT_W] == sect_q);

  always_comb begin
    if (active && hit_bank)
      rd_val = status_byte(1'b0, tog_all, !in_window, tog_sect);
    else if (held && hit_sect)
      rd_val = status_byte(1'b1, tog_all, !in_window, tog_sect);
    else
      rd_val = ERASED_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= ERASED_BYTE;
      tog_all  <= 1'b0;
      tog_sect <= 1'b0;
    end else if (launch) begin
      tog_all  <= 1'b0;
      tog_sect <= 1'b0;
      if (rd_en) rdata <= rd_val;
    end else if (rd_en) begin
      rdata <= rd_val;
      if (active && hit_bank) tog_all <= !tog_all;
      if ((active || held) && hit_sect) tog_sect <= !tog_sect;
    end
  end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int         ADDR_W      = 12,
  parameter int         SECT_W      = 4,
  parameter int         BANK_W      = 2,
  parameter int         TIMEOUT_CYC = 16,
  parameter int         ERASE_CYC   = 40,
  parameter logic [7:0] ERASED_BYTE = 8'hFF
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_n,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [2**BANK_W-1:0] bank_busy
);

  localparam int NBANK = 2**BANK_W;
  localparam int MAXC  = (TIMEOUT_CYC > ERASE_CYC) ? TIMEOUT_CYC : ERASE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  // Named events for the bound checker.
  logic             we_n_q, wr_commit, eng_idle;
  logic             launch_chip, launch_sector, suspend_hit, resume_hit;
  logic             erase_done, ignored_wr, in_window, mode_chip, eng_active;
  eng_state_t       eng_state;
  logic [CNT_W-1:0] eng_cnt;
  logic [SECT_W-1:0] sect_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_n_q <= 1'b1;
    else        we_n_q <= we_n;
  end

  assign wr_commit  = !we_n_q && we_n;
  assign eng_idle   = (eng_state == ENG_IDLE);
  assign eng_active = (eng_state == ENG_WINDOW) || (eng_state == ENG_RUN);
  assign ignored_wr = wr_commit && !eng_idle && !suspend_hit && !resume_hit;

  fes_cmd_decoder u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_commit     (wr_commit),
    .eng_idle      (eng_idle),
    .key_addr      (addr[UNLOCK_AW-1:0]),
    .wdata         (wdata),
    .launch_chip   (launch_chip),
    .launch_sector (launch_sector)
  );

  fes_erase_engine #(
    .SECT_W      (SECT_W),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ERASE_CYC   (ERASE_CYC),
    .CNT_W       (CNT_W)
  ) u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch_chip   (launch_chip),
    .launch_sector (launch_sector),
    .sect_in       (addr[ADDR_W-1 -: SECT_W]),
    .hold_req      (wr_commit && (wdata == CODE_HOLD)),
    .resume_req    (wr_commit && (wdata == CODE_SECTOR)),
    .state         (eng_state),
    .cnt           (eng_cnt),
    .mode_chip     (mode_chip),
    .sect_q        (sect_q),
    .in_window     (in_window),
    .suspend_hit   (suspend_hit),
    .resume_hit    (resume_hit),
    .erase_done    (erase_done)
  );

  fes_status_port #(
    .ADDR_W      (ADDR_W),
    .SECT_W      (SECT_W),
    .BANK_W      (BANK_W),
    .ERASED_BYTE (ERASED_BYTE)
  ) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .state     (eng_state),
    .mode_chip (mode_chip),
    .sect_q    (sect_q),
    .in_window (in_window),
    .launch    (launch_chip || launch_sector),
    .rdata     (rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_busy[b] = eng_active &&
                          (mode_chip || (sect_q[SECT_W-1 -: BANK_W] == BANK_W'(b)));
  end

endmodule

// File: rtl/flash_erase_checker.sv
module flash_erase_checker
  import flash_erase_pkg::*;
#(
  parameter int         NBANK       = 4,
  parameter int         CNT_W       = 6,
  parameter logic [7:0] ERASED_BYTE = 8'hFF
)(
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [7:0]       rdata,
  input logic [NBANK-1:0] bank_busy,
  input eng_state_t       eng_state,
  input logic [CNT_W-1:0] eng_cnt,
  input logic             mode_chip,
  input logic             launch_chip,
  input logic             launch_sector,
  input logic             suspend_hit,
  input logic             ignored_wr,
  input logic             erase_done
);

  assert_busy_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy) || (&bank_busy));

  assert_chip_all_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_chip |=> (&bank_busy));

  assert_sector_one_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_sector |=> ($countones(bank_busy) == 1));

  assert_chip_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ignored_wr && mode_chip && eng_cnt != '0) |=> $stable(eng_state));

  assert_chip_no_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chip |-> (eng_state != ENG_SUSP));

  assert_sector_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ignored_wr && eng_cnt != '0) |=> $stable(eng_state));

  assert_hold_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_hit |=> (eng_state == ENG_SUSP) && $stable(eng_cnt) && (bank_busy == '0));

  assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |=> (bank_busy == '0));

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && eng_state == ENG_IDLE) |=> (rdata == ERASED_BYTE));

endmodule

bind flash_erase_seq flash_erase_checker #(
  .NBANK       (2**BANK_W),
  .CNT_W       (CNT_W),
  .ERASED_BYTE (ERASED_BYTE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_en         (rd_en),
  .rdata         (rdata),
  .bank_busy     (bank_busy),
  .eng_state     (eng_state),
  .eng_cnt       (eng_cnt),
  .mode_chip     (mode_chip),
  .launch_chip   (launch_chip),
  .launch_sector (launch_sector),
  .suspend_hit   (suspend_hit),
  .ignored_wr    (ignored_wr),
  .erase_done    (erase_done)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int T  = 16;
  localparam int N  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we_n = 1'b1;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [3:0]    bank_busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic m6, m2;   // bench model of the two toggle bits

  flash_erase_seq #(.TIMEOUT_CYC(T), .ERASE_CYC(N)) uut (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .bank_busy(bank_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic d7, input logic d6, input logic d3, input logic d2);
    return {d7, d6, 2'b00, d3, d2, 2'b00};
  endfunction

  // Commit edge of the write is the value of cyc on return.
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, output int edge_no);
    addr = a; wdata = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); edge_no = cyc;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic unlock_setup();
    int e;
    wr(12'h555, 8'hAA, e); wr(12'h2AA, 8'h55, e); wr(12'h555, 8'h80, e);
    wr(12'h555, 8'hAA, e); wr(12'h2AA, 8'h55, e);
  endtask

  task automatic launch(input logic [AW-1:0] a, input logic [7:0] code, output int e);
    unlock_setup();
    wr(a, code, e);
    m6 = 1'b0; m2 = 1'b0;
  endtask

  task automatic wait_idle(output int f);
    f = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (bank_busy == 4'b0000) begin f = cyc; break; end
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(bank_busy, 0, "R12 busy after reset");
    rd(12'h123, d);
    check(d, 8'hFF, "R13 read after reset");
  endtask

  task automatic t_bad_sequence();
    int e;
    // wrong address on step 3, then the remaining steps
    wr(12'h555, 8'hAA, e); wr(12'h2AA, 8'h55, e); wr(12'h2AA, 8'h80, e);
    wr(12'h555, 8'hAA, e); wr(12'h2AA, 8'h55, e); wr(12'h555, 8'h10, e);
    @(negedge clk);
    check(bank_busy, 0, "R1 broken step 3");
    // wrong final code
    unlock_setup(); wr(12'h555, 8'h20, e);
    @(negedge clk);
    check(bank_busy, 0, "R1 unknown final code");
  endtask

  task automatic t_chip();
    int e, f, x;
    logic [7:0] d;
    launch(12'h555, 8'h10, e);
    check(bank_busy, 4'hF, "R2 all banks busy");
    rd(12'h0AB, d); check(d, stat(0, m6, 1, m2), "R5 chip status 1"); m6 = ~m6; m2 = ~m2;
    rd(12'hF00, d); check(d, stat(0, m6, 1, m2), "R6 chip status 2"); m6 = ~m6; m2 = ~m2;
    wr(12'h123, 8'hB0, x);      // suspend ignored in chip mode
    check(bank_busy, 4'hF, "R8 suspend ignored");
    wr(12'h555, 8'hAA, x);      // start of a sequence, ignored
    wait_idle(f);
    check(f, e + N, "R2/R8 chip completion edge");
  endtask

  task automatic t_sector();
    int e, f, x;
    logic [7:0] d;
    launch(12'h5C3, 8'h30, e);  // sector 5, bank 1
    check(bank_busy, 4'b0010, "R3 only bank 1 busy");
    rd(12'h512, d); check(d, stat(0, m6, 0, m2), "R4 window read in sector"); m6 = ~m6; m2 = ~m2;
    rd(12'h4FF, d); check(d, stat(0, m6, 0, m2), "R6 bank read outside sector"); m6 = ~m6;
    rd(12'h500, d); check(d, stat(0, m6, 0, m2), "R6 sector toggle held then flips"); m6 = ~m6; m2 = ~m2;
    rd(12'h8AA, d); check(d, 8'hFF, "R7 other bank reads array");
    wr(12'h555, 8'hF0, x);      // ignored
    wr(12'h2AA, 8'h80, x);      // ignored
    while (cyc < e + T - 1) @(negedge clk);
    rd(12'h5AA, d); check(d, stat(0, m6, 0, m2), "R4 last window edge"); m6 = ~m6; m2 = ~m2;
    rd(12'h5AA, d); check(d, stat(0, m6, 1, m2), "R4 first edge after window"); m6 = ~m6; m2 = ~m2;
    wait_idle(f);
    check(f, e + T + N, "R3/R9 sector completion edge");
    rd(12'h5AA, d); check(d, 8'hFF, "R11 read after completion");
  endtask

  task automatic t_suspend();
    int e, es, er, f, x;
    logic [7:0] d;
    logic h6;
    launch(12'h3A0, 8'h30, e);  // sector 3, bank 0
    while (cyc < e + T + 5) @(negedge clk);
    wr(12'h000, 8'hB0, es);
    check(bank_busy, 0, "R10 busy cleared on suspend");
    h6 = m6;
    rd(12'h311, d); check(d, stat(1, h6, 1, m2), "R10 suspended read 1"); m2 = ~m2;
    rd(12'h322, d); check(d, stat(1, h6, 1, m2), "R10 suspended read 2"); m2 = ~m2;
    rd(12'h2FF, d); check(d, 8'hFF, "R10 other sector reads array");
    wr(12'h555, 8'h80, x);      // ignored while held
    repeat (7) @(negedge clk);
    wr(12'h777, 8'h30, er);
    check(bank_busy, 4'b0001, "R10 resume busy");
    wait_idle(f);
    check(f, e + T + N + (er - es + 1), "R10 completion after resume");
  endtask

  task automatic t_abort();
    int e;
    logic [7:0] d;
    launch(12'h555, 8'h10, e);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(bank_busy, 0, "R12 reset aborts at once");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(12'h100, d); check(d, 8'hFF, "R12 read after abort");
    launch(12'hC00, 8'h30, e);
    check(bank_busy, 4'b1000, "R11 new sequence accepted");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m6 = 1'b0; m2 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_sequence();
    t_chip();
    t_sector();
    t_suspend();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule